// File: doc/BRIEF.md
# Voice Interrupt Acknowledge Selector

This block sits in the register interface of a wavetable synthesizer and settles which pending per-voice interrupt the host services next. Each voice can hold two kinds of pending interrupt: a wave-end interrupt and a volume-ramp interrupt. The voice engines raise these through one set-strobe vector per kind. Inside the block they become pending bits.

The host acknowledges one interrupt by writing the acknowledge code 0x8F to the function-select register. The block then does the following in the same clock:

- It picks one pending interrupt. Wave-end interrupts come before volume-ramp interrupts, and within a kind the lowest voice wins.
- It clears that pending bit.
- It pulses a clear strobe so the voice-register storage outside the block can drop the IRQ flag (bit 7) of that voice's wave or ramp control register.
- It latches an identification byte that the host reads back while the function select still holds 0x8F.

Two summary status bits follow the pending bits: bit 5 for wave-end and bit 6 for volume-ramp. They are merged with the other interrupt sources of the chip, and the interrupt line is the OR of the merged byte. A write to the reset register with bit 0 low wipes every pending bit.

Top module: `voice_irq_ack`

## Requirements
- R1: Only a write of 0x8F to the function-select register triggers an acknowledge. A write of any other value leaves the pending state, the result byte and the clear strobe untouched.
- R2: When any wave-end bit is pending, a wave-end interrupt is acknowledged. A volume-ramp bit is chosen only when no wave-end bit is pending.
- R3: Within the chosen kind, the lowest-numbered pending voice (0 to 30) is acknowledged.
- R4: The latched result byte is 0x60 OR voice for wave-end, 0x80 OR voice for volume-ramp, and 0xE8 when nothing is pending.
- R5: An acknowledge clears exactly the selected pending bit and leaves all other pending bits set.
- R6: During the acknowledge cycle, vctl_clr is high. vctl_clr_ramp is 0 for wave-end and 1 for volume-ramp, and vctl_clr_voice carries the voice. With nothing pending, vctl_clr stays low.
- R7: irq_summary bit 5 is high while any wave-end bit is pending, and bit 6 is high while any volume-ramp bit is pending. Each drops on the clock after its last pending bit is cleared.
- R8: irq_summary takes bits 0-4 and 7 from other_irq, and bits 5 and 6 of other_irq are ignored. irq_line is high exactly when irq_summary is nonzero.
- R9: A write to the reset register with host_wdata bit 0 low clears all pending bits of both kinds. With bit 0 high, the write has no effect.
- R10: rd_data shows the latched result byte while the function select holds 0x8F and 0x00 otherwise. Reading has no side effect.
- R11: When a set strobe and an acknowledge clear hit the same voice and kind in one cycle, the bit stays pending.
- R12: The synchronous reset clears all pending bits and the function select. It sets the result byte to 0xE8 and drives irq_summary and irq_line low (with other_irq zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fsel_wr | input | 1 | Write strobe for the function-select register |
| rstreg_wr | input | 1 | Write strobe for the reset register |
| host_wdata | input | 8 | Host write data |
| wave_set | input | 31 | Per-voice wave-end set strobes |
| ramp_set | input | 31 | Per-voice volume-ramp set strobes |
| other_irq | input | 8 | Summary bits from other interrupt sources (bits 5, 6 unused) |
| fsel | output | 8 | Current function-select value |
| rd_data | output | 8 | Read data for the acknowledge function |
| vctl_clr | output | 1 | Voice control IRQ-flag clear strobe |
| vctl_clr_ramp | output | 1 | Clear target: 0 wave control, 1 ramp control |
| vctl_clr_voice | output | 5 | Voice index of the clear |
| irq_summary | output | 8 | Merged interrupt status byte |
| irq_line | output | 1 | Interrupt request line |

## Verification
The hardest situation to reach from the ports is a collision: a set strobe for the very voice being acknowledged arriving in the acknowledge cycle itself. The stimulus first raises a single wave-end bit. It then drives that voice's set strobe during the same cycle as the 0x8F write. A second acknowledge must then return the same voice, and only after that may the summary bit fall. Pending bits are never visible directly, so every claim about them is read back through chains of acknowledges and the summary bits.

// File: rtl/vack_pkg.sv
package vack_pkg;

    localparam int VOICES     = 31;
    localparam int VID_W      = 5;
    localparam int BYTE_W     = 8;
    localparam int STAT_WAVE  = 5;
    localparam int STAT_RAMP  = 6;

    localparam logic [BYTE_W-1:0] FN_ACK    = 8'h8F;
    localparam logic [BYTE_W-1:0] TAG_WAVE  = 8'h60;
    localparam logic [BYTE_W-1:0] TAG_RAMP  = 8'h80;
    localparam logic [BYTE_W-1:0] CODE_IDLE = 8'hE8;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_WAVE = 2'd1,
        SRC_RAMP = 2'd2
    } src_e;

    typedef struct packed {
        src_e             src;
        logic [VID_W-1:0] voice;
    } pick_t;

    function automatic logic [BYTE_W-1:0] encode_pick(input pick_t p);
        logic [BYTE_W-1:0] v;
        v = {{(BYTE_W-VID_W){1'b0}}, p.voice};
        case (p.src)
            SRC_WAVE: return TAG_WAVE | v;
            SRC_RAMP: return TAG_RAMP | v;
            default:  return CODE_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/vack_first_set.sv
module vack_first_set #(
    parameter int W  = 31,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  onehot
);

    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    assign found  = |req;
    assign onehot = req & (~req + {{(W-1){1'b0}}, 1'b1});

    always_comb begin
        if (found) begin
            assert_pick_is_request_R3: assert (req[idx] && onehot[idx]);
        end
        assert_single_grant_R5: assert ($onehot0(onehot));
    end

endmodule

// File: rtl/vack_pend_bank.sv
module vack_pend_bank #(
    parameter int NV = 31
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NV-1:0] set_i,
    input  logic [NV-1:0] clr_i,
    input  logic          wipe_i,
    output logic [NV-1:0] pend_o
);

    logic [NV-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst || wipe_i) pend_q <= '0;
        else               pend_q <= (pend_q & ~clr_i) | set_i;
    end

    assign pend_o = pend_q;

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
        !wipe_i |=> ((pend_q & $past(set_i)) == $past(set_i)));

    assert_clear_takes_R5: assert property (@(posedge clk) disable iff (rst)
        !wipe_i |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

    assert_wipe_empties_R9: assert property (@(posedge clk) disable iff (rst)
        wipe_i |=> (pend_q == '0));

endmodule

// File: rtl/vack_select.sv
module vack_select
    import vack_pkg::*;
#(
    parameter int NV = 31
) (
    input  logic [NV-1:0] wave_pend,
    input  logic [NV-1:0] ramp_pend,
    output pick_t         pick,
    output logic [NV-1:0] wave_mask,
    output logic [NV-1:0] ramp_mask
);

    localparam int NK = 2;
    localparam int IW = $clog2(NV);

    logic [NV-1:0] req_k [NK];
    logic [NV-1:0] hot_k [NK];
    logic [IW-1:0] idx_k [NK];
    logic          fnd_k [NK];

    assign req_k[0] = wave_pend;
    assign req_k[1] = ramp_pend;

    for (genvar k = 0; k < NK; k++) begin : g_kind
        vack_first_set #(.W(NV), .IW(IW)) u_first (
            .req    (req_k[k]),
            .found  (fnd_k[k]),
            .idx    (idx_k[k]),
            .onehot (hot_k[k])
        );
    end

    always_comb begin
        pick      = '{src: SRC_NONE, voice: '0};
        wave_mask = '0;
        ramp_mask = '0;
        if (fnd_k[0]) begin
            pick.src   = SRC_WAVE;
            pick.voice = VID_W'(idx_k[0]);
            wave_mask  = hot_k[0];
        end else if (fnd_k[1]) begin
            pick.src   = SRC_RAMP;
            pick.voice = VID_W'(idx_k[1]);
            ramp_mask  = hot_k[1];
        end
    end

    always_comb begin
        if (|wave_pend) begin
            assert_wave_first_R2: assert (pick.src == SRC_WAVE && ramp_mask == '0);
        end
        if (wave_pend == '0 && ramp_pend == '0) begin
            assert_idle_pick_R4: assert (pick.src == SRC_NONE);
        end
    end

endmodule

// File: rtl/voice_irq_ack.sv
module voice_irq_ack
    import vack_pkg::*;
#(
    parameter int NV = VOICES,
    localparam int VW = $clog2(NV)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fsel_wr,
    input  logic          rstreg_wr,
    input  logic [7:0]    host_wdata,
    input  logic [NV-1:0] wave_set,
    input  logic [NV-1:0] ramp_set,
    input  logic [7:0]    other_irq,
    output logic [7:0]    fsel,
    output logic [7:0]    rd_data,
    output logic          vctl_clr,
    output logic          vctl_clr_ramp,
    output logic [VW-1:0] vctl_clr_voice,
    output logic [7:0]    irq_summary,
    output logic          irq_line
);

    logic [NV-1:0] wave_pend, ramp_pend;
    logic [NV-1:0] wave_mask, ramp_mask;
    logic [NV-1:0] wave_clr, ramp_clr;
    pick_t         pick;
    logic          ack_fire, wipe;
    logic [7:0]    fsel_q, result_q;
    logic          stat_wave_q, stat_ramp_q;
    logic          unused_other;

    assign ack_fire = fsel_wr && (host_wdata == FN_ACK);
    assign wipe     = rstreg_wr && !host_wdata[0];
    assign wave_clr = ack_fire ? wave_mask : '0;
    assign ramp_clr = ack_fire ? ramp_mask : '0;

    vack_select #(.NV(NV)) u_select (
        .wave_pend (wave_pend),
        .ramp_pend (ramp_pend),
        .pick      (pick),
        .wave_mask (wave_mask),
        .ramp_mask (ramp_mask)
    );

    vack_pend_bank #(.NV(NV)) u_wave_bank (
        .clk    (clk),
        .rst    (rst),
        .set_i  (wave_set),
        .clr_i  (wave_clr),
        .wipe_i (wipe),
        .pend_o (wave_pend)
    );

    vack_pend_bank #(.NV(NV)) u_ramp_bank (
        .clk    (clk),
        .rst    (rst),
        .set_i  (ramp_set),
        .clr_i  (ramp_clr),
        .wipe_i (wipe),
        .pend_o (ramp_pend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fsel_q   <= '0;
            result_q <= CODE_IDLE;
        end else begin
            if (fsel_wr)  fsel_q   <= host_wdata;
            if (ack_fire) result_q <= encode_pick(pick);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            stat_wave_q <= 1'b0;
            stat_ramp_q <= 1'b0;
        end else begin
            if (|wave_set)
                stat_wave_q <= 1'b1;
            else if (ack_fire && pick.src == SRC_WAVE && (wave_pend & ~wave_mask) == '0)
                stat_wave_q <= 1'b0;
            if (|ramp_set)
                stat_ramp_q <= 1'b1;
            else if (ack_fire && pick.src == SRC_RAMP && (ramp_pend & ~ramp_mask) == '0)
                stat_ramp_q <= 1'b0;
        end
    end

    assign fsel           = fsel_q;
    assign rd_data        = (fsel_q == FN_ACK) ? result_q : 8'h00;
    assign vctl_clr       = ack_fire && (pick.src != SRC_NONE);
    assign vctl_clr_ramp  = vctl_clr && (pick.src == SRC_RAMP);
    assign vctl_clr_voice = vctl_clr ? VW'(pick.voice) : '0;
    assign unused_other   = ^other_irq[STAT_RAMP:STAT_WAVE];

    always_comb begin
        irq_summary            = other_irq;
        irq_summary[STAT_WAVE] = stat_wave_q;
        irq_summary[STAT_RAMP] = stat_ramp_q;
    end
    assign irq_line = |irq_summary;

    assert_trigger_only_R1: assert property (@(posedge clk) disable iff (rst)
        (!ack_fire && !wipe) |=> (($past(wave_pend) & ~wave_pend) == '0
                                  && ($past(ramp_pend) & ~ramp_pend) == '0));

    assert_result_code_R4: assert property (@(posedge clk) disable iff (rst)
        ack_fire |=> (rd_data == CODE_IDLE || rd_data[7:5] == 3'b011 || rd_data[7:5] == 3'b100));

    assert_no_clear_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (ack_fire && wave_pend == '0 && ramp_pend == '0) |-> !vctl_clr);

    assert_wave_status_R7: assert property (@(posedge clk) disable iff (rst)
        (|wave_pend) == irq_summary[STAT_WAVE]);

    assert_ramp_status_R7: assert property (@(posedge clk) disable iff (rst)
        (|ramp_pend) == irq_summary[STAT_RAMP]);

    assert_read_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (!fsel_wr) |=> $stable(rd_data));

endmodule

// File: tb/voice_irq_ack_tb.sv
module voice_irq_ack_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 31;
    localparam int NVEC = 9;
    localparam int WATCHDOG = 5000;

    // wave_set, ramp_set, expected result byte
    localparam logic [69:0] VEC [NVEC] = '{
        {31'h0000_0000, 31'h0000_0000, 8'hE8},
        {31'h0000_0088, 31'h0000_0002, 8'h63},
        {31'h0000_0000, 31'h0000_0000, 8'h67},
        {31'h0000_0000, 31'h0000_0000, 8'h81},
        {31'h0000_0000, 31'h0000_0000, 8'hE8},
        {31'h0000_0000, 31'h4000_0001, 8'h80},
        {31'h4000_0000, 31'h0000_0000, 8'h7E},
        {31'h0000_0000, 31'h0000_0000, 8'h9E},
        {31'h7FFF_FFFF, 31'h0000_0000, 8'h60}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          fsel_wr, rstreg_wr;
    logic [7:0]    host_wdata;
    logic [NV-1:0] wave_set, ramp_set;
    logic [7:0]    other_irq;
    logic [7:0]    fsel, rd_data, irq_summary;
    logic          vctl_clr, vctl_clr_ramp, irq_line;
    logic [4:0]    vctl_clr_voice;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    voice_irq_ack #(.NV(NV)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .fsel_wr        (fsel_wr),
        .rstreg_wr      (rstreg_wr),
        .host_wdata     (host_wdata),
        .wave_set       (wave_set),
        .ramp_set       (ramp_set),
        .other_irq      (other_irq),
        .fsel           (fsel),
        .rd_data        (rd_data),
        .vctl_clr       (vctl_clr),
        .vctl_clr_ramp  (vctl_clr_ramp),
        .vctl_clr_voice (vctl_clr_voice),
        .irq_summary    (irq_summary),
        .irq_line       (irq_line)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        fsel_wr = 1'b0; rstreg_wr = 1'b0; host_wdata = 8'h00;
        wave_set = '0; ramp_set = '0;
    endtask

    // Drive an fsel write for one cycle; sample strobes mid-cycle, results after the edge.
    task automatic write_fsel(input logic [7:0] val, input logic [NV-1:0] wset);
        fsel_wr = 1'b1; host_wdata = val; wave_set = wset;
        #1;
    endtask

    task automatic finish_cycle();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_ack(input string tag, input logic [7:0] exp);
        write_fsel(8'h8F, '0);
        finish_cycle();
        check(tag, rd_data, exp);
    endtask

    task automatic raise(input logic [NV-1:0] w, input logic [NV-1:0] r);
        wave_set = w; ramp_set = r;
        finish_cycle();
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            report();
        end
    end

    initial begin
        idle_inputs();
        other_irq = 8'h00;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        check("R12 fsel", fsel, 8'h00);
        check("R12 rd_data", rd_data, 8'h00);
        check("R12 summary", irq_summary, 8'h00);
        check("R12 line", irq_line, 1'b0);
        check("R12 clr", vctl_clr, 1'b0);

        // Table walk: R2 R3 R4 R5
        for (int i = 0; i < NVEC; i++) begin
            raise(VEC[i][69:39], VEC[i][38:8]);
            do_ack($sformatf("R2/R3/R4/R5 vec%0d", i), VEC[i][7:0]);
        end

        // Voices 1..30 wave pending now
        check("R7 wave bit", irq_summary[5], 1'b1);
        check("R7 ramp bit", irq_summary[6], 1'b0);
        check("R8 line", irq_line, 1'b1);

        // R9: bit0 high has no effect, bit0 low wipes
        rstreg_wr = 1'b1; host_wdata = 8'h01; finish_cycle();
        check("R9 keep", irq_summary, 8'h20);
        rstreg_wr = 1'b1; host_wdata = 8'h06; finish_cycle();
        check("R9 wipe summary", irq_summary, 8'h00);
        check("R9 wipe line", irq_line, 1'b0);
        do_ack("R9 nothing left", 8'hE8);

        // R6: ramp voice 9 clear strobe
        raise('0, 31'h0000_0200);
        write_fsel(8'h8F, '0);
        check("R6 clr", vctl_clr, 1'b1);
        check("R6 kind", vctl_clr_ramp, 1'b1);
        check("R6 voice", vctl_clr_voice, 5'd9);
        finish_cycle();
        check("R4 ramp9", rd_data, 8'h89);
        check("R7 ramp dropped", irq_summary[6], 1'b0);
        check("R8 line dropped", irq_line, 1'b0);
        write_fsel(8'h8F, '0);
        check("R6 idle no clr", vctl_clr, 1'b0);
        finish_cycle();

        // R6 wave kind, then R11 collision on voice 4
        raise(31'h0000_0010, '0);
        write_fsel(8'h8F, 31'h0000_0010);
        check("R6 wave kind", vctl_clr_ramp, 1'b0);
        check("R6 wave voice", vctl_clr_voice, 5'd4);
        finish_cycle();
        check("R11 first", rd_data, 8'h64);
        check("R11 still pending", irq_summary[5], 1'b1);
        do_ack("R11 again", 8'h64);
        check("R7 wave dropped", irq_summary[5], 1'b0);

        // R1: non-ack fsel write does nothing
        raise(31'h0000_0004, '0);
        write_fsel(8'h8E, '0);
        check("R1 no clr", vctl_clr, 1'b0);
        finish_cycle();
        check("R10 other fsel", rd_data, 8'h00);
        check("R1 fsel value", fsel, 8'h8E);
        check("R1 pending kept", irq_summary[5], 1'b1);
        do_ack("R1 ack after", 8'h62);

        // R10: reads are stable with no writes
        repeat (3) @(negedge clk);
        check("R10 stable", rd_data, 8'h62);
        do_ack("R10 empty", 8'hE8);

        // R8: other sources
        other_irq = 8'h60; #1;
        check("R8 ignore 5/6", irq_summary, 8'h00);
        check("R8 line low", irq_line, 1'b0);
        other_irq = 8'h81; #1;
        check("R8 pass", irq_summary, 8'h81);
        check("R8 line high", irq_line, 1'b1);
        other_irq = 8'h00;

        done = 1'b1;
        report();
    end

endmodule